// File: doc/BRIEF.md
# GPIO Group Event Aggregator

This block gathers per-pad event pulses from one group of general-purpose pads and keeps two separate banks of sticky bits for them. One is a host interrupt bank; the other is a wake bank. Each bank has a status word and an enable word, and both are reached through a small word-wide register port. The host interrupt bank feeds one shared interrupt line. The wake bank feeds one wake line.

Each pad has a host-ownership input. A pad held in firmware mode (ownership 0) never sets its host interrupt status bit, but it can still set its wake status bit. Each pad also has a routing input that sends its wake to the system control path. While that input is high, the pad does not drive the wake line.

The register word may be wider than the number of pads that are populated. The bits above the last populated pad never set and always read zero. Status bits are cleared by writing ones to them. If a new event arrives in the same cycle as a clear of the same bit, the bit stays set.

Top module: `gpio_evt_agg`

## Requirements
- R1: Host interrupt status (address 0) is write-one-to-clear. A written 1 clears its bit, and a written 0 leaves its bit unchanged. An event on pad i sets bit i in the cycle after the event is presented.
- R2: `irq_out` is a register holding the OR over all pads of (host status AND host enable, address 1). It follows the status and enable registers one cycle later. A pending pad whose enable is 0 does not raise it.
- R3: A pad whose `pad_host_own` bit is 0 never sets its host interrupt status bit.
- R4: Wake status (address 2) sets on every pad event, whatever the ownership. It is write-one-to-clear, with the same rule as R1.
- R5: `wake_out` is a register holding the OR over all pads of (wake status AND wake enable, address 3, AND NOT `pad_sci_route`). It lags its inputs by one cycle.
- R6: Bits at positions NUM_PADS and above never set, in any of the four words, and they read 0.
- R7: Writing all ones to address 0 and zero to address 1 leaves no host status pending, no host enable set, and `irq_out` low.
- R8: If an event and a write-one-to-clear hit the same status bit in the same cycle, the bit stays set.
- R9: A read presented with `reg_rd` returns its word on `reg_rdata` after one clock edge. The word returned is the value from before any write in that same cycle. `reg_rdata` holds its value between reads.
- R10: After reset, all four words are 0, and `irq_out`, `wake_out` and `reg_rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_evt | input | NUM_PADS | Per-pad event pulse, one cycle per event |
| pad_host_own | input | NUM_PADS | 1 = pad in host mode, 0 = firmware mode |
| pad_sci_route | input | NUM_PADS | 1 = pad wake routed to the system control path |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | 0 host status, 1 host enable, 2 wake status, 3 wake enable |
| reg_wdata | input | WORD_W | Write data |
| reg_rdata | output | WORD_W | Read data, one cycle after `reg_rd` |
| irq_out | output | 1 | Shared host interrupt |
| wake_out | output | 1 | Wake request |

## Verification
The assertions take for granted that the ownership and routing inputs are driven to known values from reset onward. The one-cycle status-set check assumes every event is a single-cycle pulse on a pad that is seen in the same cycle. The stimulus changes all inputs only on the falling clock edge. It holds ownership and routing steady around each event and each wake observation, and it never drives a pad index above the populated count, because those pads have no input pins.

// File: rtl/gpio_agg_pkg.sv
package gpio_agg_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_HOST_STS = 2'd0,
    A_HOST_EN  = 2'd1,
    A_WAKE_STS = 2'd2,
    A_WAKE_EN  = 2'd3
  } agg_addr_e;
endpackage

// File: rtl/gpio_agg_status_bank.sv
module gpio_agg_status_bank #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  input  logic [W-1:0] valid_mask,
  output logic [W-1:0] sts,
  output logic [W-1:0] collide
);
  function automatic logic [W-1:0] next_sts(input logic [W-1:0] cur,
                                            input logic [W-1:0] setv,
                                            input logic [W-1:0] clrv,
                                            input logic [W-1:0] vm);
    return ((cur & ~clrv) | setv) & vm;
  endfunction

  assign collide = set_vec & clr_vec & valid_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts <= '0;
    else        sts <= next_sts(sts, set_vec, clr_vec, valid_mask);
  end
endmodule

// File: rtl/gpio_agg_mask_reg.sv
module gpio_agg_mask_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] valid_mask,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= wdata & valid_mask;
  end
endmodule

// File: rtl/gpio_agg_line.sv
module gpio_agg_line #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pend,
  input  logic [W-1:0] allow,
  input  logic [W-1:0] block,
  output logic         line
);
  function automatic logic any_live(input logic [W-1:0] p,
                                    input logic [W-1:0] a,
                                    input logic [W-1:0] b);
    return |(p & a & ~b);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line <= 1'b0;
    else        line <= any_live(pend, allow, block);
  end
endmodule

// File: rtl/gpio_evt_agg.sv
module gpio_evt_agg #(
  parameter int unsigned NUM_PADS = 16,
  parameter int unsigned WORD_W   = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_PADS-1:0]               pad_evt,
  input  logic [NUM_PADS-1:0]               pad_host_own,
  input  logic [NUM_PADS-1:0]               pad_sci_route,
  input  logic                              reg_wr,
  input  logic                              reg_rd,
  input  logic [gpio_agg_pkg::ADDR_W-1:0]   reg_addr,
  input  logic [WORD_W-1:0]                 reg_wdata,
  output logic [WORD_W-1:0]                 reg_rdata,
  output logic                              irq_out,
  output logic                              wake_out
);
  import gpio_agg_pkg::*;

  function automatic logic [WORD_W-1:0] populated(input int unsigned n);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < WORD_W; i++) m[i] = (i < n);
    return m;
  endfunction

  localparam logic [WORD_W-1:0] POP_MASK = populated(NUM_PADS);

  logic [WORD_W-1:0] evt_w, own_w, sci_w;
  always_comb begin
    evt_w = '0; own_w = '0; sci_w = '0;
    evt_w[NUM_PADS-1:0] = pad_evt;
    own_w[NUM_PADS-1:0] = pad_host_own;
    sci_w[NUM_PADS-1:0] = pad_sci_route;
  end

  // named decode events
  logic wr_host_sts, wr_host_en, wr_wake_sts, wr_wake_en;
  assign wr_host_sts = reg_wr && (reg_addr == A_HOST_STS);
  assign wr_host_en  = reg_wr && (reg_addr == A_HOST_EN);
  assign wr_wake_sts = reg_wr && (reg_addr == A_WAKE_STS);
  assign wr_wake_en  = reg_wr && (reg_addr == A_WAKE_EN);

  logic [WORD_W-1:0] host_set, host_clr, wake_clr;
  assign host_set = evt_w & own_w;
  assign host_clr = wr_host_sts ? reg_wdata : '0;
  assign wake_clr = wr_wake_sts ? reg_wdata : '0;

  logic [WORD_W-1:0] host_sts, host_en, wake_sts, wake_en;
  logic [WORD_W-1:0] host_collide, wake_collide;

  gpio_agg_status_bank #(.W(WORD_W)) u_host_sts (
    .clk(clk), .rst_n(rst_n), .set_vec(host_set), .clr_vec(host_clr),
    .valid_mask(POP_MASK), .sts(host_sts), .collide(host_collide));

  gpio_agg_status_bank #(.W(WORD_W)) u_wake_sts (
    .clk(clk), .rst_n(rst_n), .set_vec(evt_w), .clr_vec(wake_clr),
    .valid_mask(POP_MASK), .sts(wake_sts), .collide(wake_collide));

  gpio_agg_mask_reg #(.W(WORD_W)) u_host_en (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_host_en), .wdata(reg_wdata),
    .valid_mask(POP_MASK), .q(host_en));

  gpio_agg_mask_reg #(.W(WORD_W)) u_wake_en (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_wake_en), .wdata(reg_wdata),
    .valid_mask(POP_MASK), .q(wake_en));

  gpio_agg_line #(.W(WORD_W)) u_irq_line (
    .clk(clk), .rst_n(rst_n), .pend(host_sts), .allow(host_en),
    .block('0), .line(irq_out));

  gpio_agg_line #(.W(WORD_W)) u_wake_line (
    .clk(clk), .rst_n(rst_n), .pend(wake_sts), .allow(wake_en),
    .block(sci_w), .line(wake_out));

  logic [WORD_W-1:0] rd_mux;
  always_comb begin
    unique case (reg_addr)
      A_HOST_STS: rd_mux = host_sts;
      A_HOST_EN:  rd_mux = host_en;
      A_WAKE_STS: rd_mux = wake_sts;
      default:    rd_mux = wake_en;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/gpio_evt_agg_chk.sv
module gpio_evt_agg_chk #(
  parameter int unsigned NP = 16,
  parameter int unsigned W  = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [W-1:0]  evt_w,
  input logic [W-1:0]  own_w,
  input logic [W-1:0]  sci_w,
  input logic          reg_wr,
  input logic [1:0]    reg_addr,
  input logic [W-1:0]  reg_wdata,
  input logic [W-1:0]  host_sts,
  input logic [W-1:0]  host_en,
  input logic [W-1:0]  wake_sts,
  input logic [W-1:0]  wake_en,
  input logic [W-1:0]  reg_rdata,
  input logic          irq_out,
  input logic          wake_out
);
  function automatic logic [W-1:0] upper_bits(input int unsigned n);
    logic [W-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < W; i++) m[i] = (i >= n);
    return m;
  endfunction
  localparam logic [W-1:0] UPPER = upper_bits(NP);

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  logic [W-1:0] host_wr1, wake_wr1;
  assign host_wr1 = (reg_wr && reg_addr == 2'd0) ? reg_wdata : '0;
  assign wake_wr1 = (reg_wr && reg_addr == 2'd2) ? reg_wdata : '0;

  // R1: a host status bit only falls where a 1 was written to it
  p_keep_unless_w1c_r1: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (($past(host_sts) & ~host_sts & ~$past(host_wr1)) == '0));

  // R4: the same rule for wake status
  p_wake_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (($past(wake_sts) & ~wake_sts & ~$past(wake_wr1)) == '0));

  // R3: a newly set host bit must have been host owned
  p_firmware_no_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((host_sts & ~$past(host_sts) & ~$past(own_w)) == '0));

  // R8: an owned event leaves its bit set even under a clear
  p_event_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (($past(evt_w & own_w) & ~host_sts) == '0));

  // R2
  p_irq_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (irq_out == $past(|(host_sts & host_en))));

  // R5
  p_wake_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (wake_out == $past(|(wake_sts & wake_en & ~sci_w))));

  // R6
  p_unpopulated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((host_sts | host_en | wake_sts | wake_en | reg_rdata) & UPPER) == '0);
endmodule

bind gpio_evt_agg gpio_evt_agg_chk #(.NP(NUM_PADS), .W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_w(evt_w), .own_w(own_w), .sci_w(sci_w),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .host_sts(host_sts), .host_en(host_en), .wake_sts(wake_sts),
  .wake_en(wake_en), .reg_rdata(reg_rdata), .irq_out(irq_out),
  .wake_out(wake_out));

// File: tb/gpio_evt_agg_test.sv
module gpio_evt_agg_test;
  localparam int unsigned NP = 12;
  localparam int unsigned W  = 16;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [W-1:0] POP = (W'(1) << NP) - W'(1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] pad_evt = '0, pad_host_own = '1, pad_sci_route = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [W-1:0] reg_wdata = '0, reg_rdata;
  logic irq_out, wake_out;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [W-1:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_evt_agg #(.NUM_PADS(NP), .WORD_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .pad_evt(pad_evt), .pad_host_own(pad_host_own),
    .pad_sci_route(pad_sci_route), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out), .wake_out(wake_out));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; rv = reg_rdata;
  endtask

  task automatic evt(input logic [NP-1:0] v);
    @(negedge clk); pad_evt = v;
    @(negedge clk); pad_evt = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 irq", irq_out, 0);
    chk("R10 wake", wake_out, 0);
    chk("R10 rdata", reg_rdata, 0);
    rst_n = 1;
    for (int a = 0; a < 4; a++) begin rd(a[1:0]); chk("R10 word", rv, 0); end

    // R6 / R9 enable write masked to populated pads, read latency
    wr(2'd1, 16'hFFFF);
    rd(2'd1); chk("R6 host_en", rv, POP);
    wr(2'd3, 16'hFFFF);
    rd(2'd3); chk("R6 wake_en", rv, POP);
    // R9 read and write in same cycle returns old value
    @(negedge clk); reg_rd = 1; reg_wr = 1; reg_addr = 2'd3; reg_wdata = 16'h0005;
    @(negedge clk); reg_rd = 0; reg_wr = 0;
    chk("R9 old value", reg_rdata, POP);
    @(negedge clk); chk("R9 hold", reg_rdata, POP);
    rd(2'd3); chk("R9 new value", rv, 16'h0005);
    wr(2'd3, 16'h0000);

    // R1 / R2 sweep across every pad with all enabled
    for (int i = 0; i < NP; i++) begin
      evt(NP'(1) << i);
      @(negedge clk);
      chk("R2 irq raised", irq_out, 1);
      rd(2'd0); chk("R1 set", rv, W'(1) << i);
      wr(2'd0, ~(W'(1) << i));
      rd(2'd0); chk("R1 zero keeps", rv, W'(1) << i);
      wr(2'd0, W'(1) << i);
      @(negedge clk);
      chk("R2 irq dropped", irq_out, 0);
      rd(2'd0); chk("R1 cleared", rv, 0);
    end
    rd(2'd2); chk("R4 wake all set", rv, POP);
    wr(2'd2, 16'h0000);
    rd(2'd2); chk("R4 zero keeps", rv, POP);
    wr(2'd2, 16'hFFFF);
    rd(2'd2); chk("R4 cleared", rv, 0);

    // R2 enable masking
    wr(2'd1, 16'h0000);
    evt(NP'(1) << 3);
    @(negedge clk); @(negedge clk);
    chk("R2 masked", irq_out, 0);
    wr(2'd1, 16'h0008);
    @(negedge clk);
    chk("R2 enabled later", irq_out, 1);
    wr(2'd0, 16'hFFFF); @(negedge clk);

    // R3 firmware-owned pad 5
    pad_host_own = ~(NP'(1) << 5);
    wr(2'd1, POP);
    evt('1);
    rd(2'd0); chk("R3 host sts", rv, POP & ~(W'(1) << 5));
    rd(2'd2); chk("R4 wake regardless", rv, POP);
    wr(2'd0, 16'hFFFF);
    evt(NP'(1) << 5);
    @(negedge clk);
    rd(2'd0); chk("R3 alone", rv, 0);
    chk("R3 no irq", irq_out, 0);
    pad_host_own = '1;

    // R5 wake gating sweep (wake status all set from above)
    for (int i = 0; i < NP; i++) begin
      pad_sci_route = NP'(1) << i;
      wr(2'd3, W'(1) << i);
      @(negedge clk);
      chk("R5 routed off", wake_out, 0);
      pad_sci_route = '0;
      @(negedge clk); @(negedge clk);
      chk("R5 wake on", wake_out, 1);
    end
    wr(2'd2, 16'hFFFF);
    @(negedge clk);
    chk("R5 wake after clear", wake_out, 0);
    wr(2'd3, 16'h0000);

    // R8 collision: bit 4 event plus clear, bit 6 clear alone
    evt(NP'(1) << 4 | NP'(1) << 6);
    @(negedge clk);
    pad_evt = NP'(1) << 4; reg_wr = 1; reg_addr = 2'd0; reg_wdata = 16'h0050;
    @(negedge clk); pad_evt = '0; reg_wr = 0;
    rd(2'd0); chk("R8 event wins", rv, 16'h0010);

    // R7 mask and clear all
    wr(2'd1, 16'hFFFF);
    evt('1);
    wr(2'd0, 16'hFFFF);
    wr(2'd1, 16'h0000);
    @(negedge clk);
    rd(2'd0); chk("R7 sts", rv, 0);
    rd(2'd1); chk("R7 en", rv, 0);
    chk("R7 irq", irq_out, 0);
    rd(2'd2); chk("R6 wake sts", rv, POP);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule